// File: doc/BRIEF.md
# Virtual Function Capability Register File

This block holds the control and status registers of the capability that lets a physical function expose a set of virtual functions. Configuration software reads and writes it one dword at a time through a port with byte enables. The capability sits at a base dword offset that the surrounding configuration-space logic supplies. The block keeps the control bits, the requested VF count and the system page size. It reports the fixed VF identity values (first-VF offset, stride, device ID, initial and total VF counts) and the supported page-size mask, all set by parameters.

When software writes the low control byte, the block acts on the VF enable bit. With the bit set, and the requested count no larger than the total, the block drives one enable line for each VF below the requested count and publishes that count. With the bit clear, it withdraws every enable and drops the count to zero. The rest of the device uses these two outputs to bring VFs up and down. Reads are combinational, and the read port returns zero for any dword the block does not implement.

Top module: `sriov_cap_regs`

## Requirements
- R1: A write whose dword address is below `capBase`, or 16 or more dwords above it, changes no register and no output.
- R2: Control sits at capability dword 2, bits [15:0]. Only bit 0 (VF enable), bit 3 (VF memory space enable) and bit 4 (ARI-capable hierarchy) can be written. Every other control bit reads 0. The status half [31:16] reads 0.
- R3: The requested VF count sits at dword 4, bits [15:0], and all 16 bits can be written. Byte enable 0 updates bits [7:0] and byte enable 1 updates bits [15:8]. Bits [31:16] read 0.
- R4: The following dwords read back the parameter values and ignore writes:
  - dword 0: {NEXT_PTR[11:0], 4'h1, 16'h0010}
  - dword 3: {TotalVFs, InitialVFs}
  - dword 5: {stride, offset}
  - dword 6: {device ID, 16'h0}
  - dword 7: the supported page-size mask, which is 0x553 ORed with OPT_PGSIZE.
- R5: System page size sits at dword 8. Its write mask equals the supported mask, and each byte enable gates its own byte. Bits outside the mask keep their value.
- R6: A write with byte enable 0 at dword 2 and data bit 0 set, made while the requested count is no larger than TotalVFs, sets `vfEnable[i]` for every i below the count and clears the other bits. It also sets `enabledVfCount` to the count.
- R7: The same write, made while the requested count is larger than TotalVFs, leaves `vfEnable` and `enabledVfCount` unchanged. The control bit still records the written value.
- R8: A write with byte enable 0 at dword 2 and data bit 0 clear clears all of `vfEnable` and sets `enabledVfCount` to 0.
- R9: After reset, control reads 0, the requested count reads 0, system page size reads 0x1, `vfEnable` is 0 and `enabledVfCount` is 0.
- R10: Every dword in the capability other than 0, 2, 3, 4, 5, 6, 7 and 8 reads zero, and so does any address outside the capability. A write to dword 2 with byte enable 0 clear has no effect on the VF outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capBase | input | 10 | Dword index of the capability start |
| cfgDwAddr | input | 10 | Dword index of the access |
| cfgWrEn | input | 1 | Write strobe, one cycle per write |
| cfgByteEn | input | 4 | Byte enables of the write |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Combinational read data for cfgDwAddr |
| vfEnable | output | TOTAL_VFS | One enable per VF |
| enabledVfCount | output | 16 | Number of VFs enabled |

## Verification
The checker assumes that `capBase` holds steady while a write is in flight. It also assumes that `capBase` plus 16 stays inside the 10-bit dword space, so that the window test never wraps. The stimulus fixes `capBase` at a low value for the whole run. Its random addresses fall only a few dwords either side of the window, so they reach both edges without wrapping. Requested counts lean towards values near TotalVFs, which exercises both the accepted and the refused enable paths.

// File: rtl/sriov_pkg.sv
package sriov_pkg;
  localparam int CAP_DWORDS = 16;
  localparam int OFF_W = 4;
  localparam logic [OFF_W-1:0] OFF_HDR = 4'd0;
  localparam logic [OFF_W-1:0] OFF_CTRL = 4'd2;
  localparam logic [OFF_W-1:0] OFF_VFCNT = 4'd3;
  localparam logic [OFF_W-1:0] OFF_NUM = 4'd4;
  localparam logic [OFF_W-1:0] OFF_ROUTE = 4'd5;
  localparam logic [OFF_W-1:0] OFF_DEVID = 4'd6;
  localparam logic [OFF_W-1:0] OFF_SUPPG = 4'd7;
  localparam logic [OFF_W-1:0] OFF_SYSPG = 4'd8;
  localparam logic [15:0] CTRL_WMASK = 16'h0019;
  localparam logic [31:0] BASE_PGSIZE = 32'h0000_0553;

  typedef struct packed {
    logic hit;
    logic [OFF_W-1:0] off;
    logic ctrlWr;
    logic [1:0] numWr;
    logic [3:0] pgWr;
  } regStrobe_t;
endpackage

// File: rtl/sriov_ctl.sv
module sriov_ctl
  import sriov_pkg::*;
(
  input  logic [9:0] capBase,
  input  logic [9:0] cfgDwAddr,
  input  logic       cfgWrEn,
  input  logic [3:0] cfgByteEn,
  output regStrobe_t stb
);
  logic [9:0] relAddr;
  logic inWindow;

  always_comb begin
    relAddr = cfgDwAddr - capBase;
    inWindow = (cfgDwAddr >= capBase) && (relAddr < 10'(CAP_DWORDS));
    stb = '0;
    stb.hit = inWindow;
    stb.off = relAddr[OFF_W-1:0];
    if (inWindow && cfgWrEn) begin
      stb.ctrlWr = (relAddr[OFF_W-1:0] == OFF_CTRL) && cfgByteEn[0];
      if (relAddr[OFF_W-1:0] == OFF_NUM) stb.numWr = cfgByteEn[1:0];
      if (relAddr[OFF_W-1:0] == OFF_SYSPG) stb.pgWr = cfgByteEn;
    end
  end
endmodule

// File: rtl/sriov_dp.sv
module sriov_dp
  import sriov_pkg::*;
#(
  parameter int TOTAL_VFS = 8,
  parameter int INITIAL_VFS = 8,
  parameter logic [15:0] VF_OFFSET = 16'd1,
  parameter logic [15:0] VF_STRIDE = 16'd1,
  parameter logic [15:0] VF_DEVICE_ID = 16'h10ca,
  parameter logic [11:0] NEXT_PTR = 12'h000,
  parameter logic [31:0] OPT_PGSIZE = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  regStrobe_t           stb,
  input  logic [31:0]          cfgWrData,
  output logic [31:0]          cfgRdData,
  output logic [TOTAL_VFS-1:0] vfEnable,
  output logic [15:0]          enabledVfCount
);
  localparam logic [31:0] SUP_PGSIZE = BASE_PGSIZE | OPT_PGSIZE;
  localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);
  localparam logic [15:0] INIT_W = 16'(INITIAL_VFS);

  logic [15:0] ctrlReg;
  logic [15:0] numVfs;
  logic [31:0] sysPg;
  logic enGo, disGo;

  assign enGo = stb.ctrlWr && cfgWrData[0] && (numVfs <= TOTAL_W);
  assign disGo = stb.ctrlWr && !cfgWrData[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg <= '0;
    end else if (stb.ctrlWr) begin
      ctrlReg[7:0] <= cfgWrData[7:0] & CTRL_WMASK[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      numVfs <= '0;
    end else begin
      if (stb.numWr[0]) numVfs[7:0] <= cfgWrData[7:0];
      if (stb.numWr[1]) numVfs[15:8] <= cfgWrData[15:8];
    end
  end

  for (genvar b = 0; b < 4; b++) begin : g_pgByte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sysPg[8*b +: 8] <= (b == 0) ? 8'h01 : 8'h00;
      end else if (stb.pgWr[b]) begin
        sysPg[8*b +: 8] <= (cfgWrData[8*b +: 8] & SUP_PGSIZE[8*b +: 8])
                         | (sysPg[8*b +: 8] & ~SUP_PGSIZE[8*b +: 8]);
      end
    end
  end

  for (genvar i = 0; i < TOTAL_VFS; i++) begin : g_vf
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vfEnable[i] <= 1'b0;
      end else if (enGo) begin
        vfEnable[i] <= (16'(i) < numVfs);
      end else if (disGo) begin
        vfEnable[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabledVfCount <= '0;
    end else if (enGo) begin
      enabledVfCount <= numVfs;
    end else if (disGo) begin
      enabledVfCount <= '0;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (stb.hit) begin
      unique case (stb.off)
        OFF_HDR:   cfgRdData = {NEXT_PTR, 4'h1, 16'h0010};
        OFF_CTRL:  cfgRdData = {16'h0, ctrlReg};
        OFF_VFCNT: cfgRdData = {TOTAL_W, INIT_W};
        OFF_NUM:   cfgRdData = {16'h0, numVfs};
        OFF_ROUTE: cfgRdData = {VF_STRIDE, VF_OFFSET};
        OFF_DEVID: cfgRdData = {VF_DEVICE_ID, 16'h0};
        OFF_SUPPG: cfgRdData = SUP_PGSIZE;
        OFF_SYSPG: cfgRdData = sysPg;
        default:   cfgRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_pkg::*;
#(
  parameter int TOTAL_VFS = 8,
  parameter int INITIAL_VFS = 8,
  parameter logic [15:0] VF_OFFSET = 16'd1,
  parameter logic [15:0] VF_STRIDE = 16'd1,
  parameter logic [15:0] VF_DEVICE_ID = 16'h10ca,
  parameter logic [11:0] NEXT_PTR = 12'h000,
  parameter logic [31:0] OPT_PGSIZE = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [9:0]           capBase,
  input  logic [9:0]           cfgDwAddr,
  input  logic                 cfgWrEn,
  input  logic [3:0]           cfgByteEn,
  input  logic [31:0]          cfgWrData,
  output logic [31:0]          cfgRdData,
  output logic [TOTAL_VFS-1:0] vfEnable,
  output logic [15:0]          enabledVfCount
);
  regStrobe_t stb;

  sriov_ctl u_ctl (
    .capBase(capBase),
    .cfgDwAddr(cfgDwAddr),
    .cfgWrEn(cfgWrEn),
    .cfgByteEn(cfgByteEn),
    .stb(stb)
  );

  sriov_dp #(
    .TOTAL_VFS(TOTAL_VFS),
    .INITIAL_VFS(INITIAL_VFS),
    .VF_OFFSET(VF_OFFSET),
    .VF_STRIDE(VF_STRIDE),
    .VF_DEVICE_ID(VF_DEVICE_ID),
    .NEXT_PTR(NEXT_PTR),
    .OPT_PGSIZE(OPT_PGSIZE)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .stb(stb),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .vfEnable(vfEnable),
    .enabledVfCount(enabledVfCount)
  );
endmodule

// File: rtl/sriov_cap_chk.sv
module sriov_cap_chk #(
  parameter int TOTAL_VFS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [9:0]           capBase,
  input logic [9:0]           cfgDwAddr,
  input logic                 cfgWrEn,
  input logic [3:0]           cfgByteEn,
  input logic [31:0]          cfgWrData,
  input logic [TOTAL_VFS-1:0] vfEnable,
  input logic [15:0]          enabledVfCount
);
  logic missWin;
  logic ctrlHit;
  assign missWin = (cfgDwAddr < capBase) || ((cfgDwAddr - capBase) >= 10'd16);
  assign ctrlHit = cfgWrEn && (cfgDwAddr == capBase + 10'd2) && cfgByteEn[0];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    enabledVfCount <= 16'(TOTAL_VFS)); // R6
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vfEnable) == int'(enabledVfCount)); // R6
  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && missWin) |=> ($stable(vfEnable) && $stable(enabledVfCount))); // R1
  AST_DISABLE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlHit && !cfgWrData[0]) |=> (enabledVfCount == 16'd0 && vfEnable == '0)); // R8
  AST_NO_CTRL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlHit |=> ($stable(vfEnable) && $stable(enabledVfCount))); // R10
endmodule

bind sriov_cap_regs sriov_cap_chk #(.TOTAL_VFS(TOTAL_VFS)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .capBase(capBase),
  .cfgDwAddr(cfgDwAddr),
  .cfgWrEn(cfgWrEn),
  .cfgByteEn(cfgByteEn),
  .cfgWrData(cfgWrData),
  .vfEnable(vfEnable),
  .enabledVfCount(enabledVfCount)
);

// File: tb/sriov_cap_regs_tb.sv
module sriov_cap_regs_tb;
  localparam int NVF = 8;
  localparam logic [9:0] BASE = 10'h040;
  localparam logic [31:0] SUP = 32'h553;

  logic clk = 0;
  logic rst_n = 0;
  logic [9:0] capBase = BASE;
  logic [9:0] cfgDwAddr = '0;
  logic cfgWrEn = 0;
  logic [3:0] cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [NVF-1:0] vfEnable;
  logic [15:0] enabledVfCount;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] mCtrl, mNum, mCount;
  logic [31:0] mPg;

  always #10 clk = ~clk;

  sriov_cap_regs u_dut (
    .clk(clk), .rst_n(rst_n), .capBase(capBase), .cfgDwAddr(cfgDwAddr),
    .cfgWrEn(cfgWrEn), .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .vfEnable(vfEnable), .enabledVfCount(enabledVfCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int off);
    case (off)
      0: return {12'h000, 4'h1, 16'h0010};
      2: return {16'h0, mCtrl};
      3: return {16'(NVF), 16'(NVF)};
      4: return {16'h0, mNum};
      5: return {16'd1, 16'd1};
      6: return {16'h10ca, 16'h0};
      7: return SUP;
      8: return mPg;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input int off);
    case (off)
      2: return "R2";
      4: return "R3";
      8: return "R5";
      0, 3, 5, 6, 7: return "R4";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [NVF-1:0] expVec(input logic [15:0] n);
    logic [NVF-1:0] v = '0;
    for (int i = 0; i < NVF; i++) v[i] = (16'(i) < n);
    return v;
  endfunction

  task automatic modelWrite(input int off, input logic [3:0] be, input logic [31:0] d);
    if (off < 0 || off >= 16) return;
    if (off == 2 && be[0]) begin
      mCtrl = {8'h0, d[7:0] & 8'h19};
      if (!d[0]) mCount = 0;
      else if (mNum <= 16'(NVF)) mCount = mNum;
    end
    if (off == 4) begin
      if (be[0]) mNum[7:0] = d[7:0];
      if (be[1]) mNum[15:8] = d[15:8];
    end
    if (off == 8)
      for (int b = 0; b < 4; b++)
        if (be[b]) mPg[8*b +: 8] = (d[8*b +: 8] & SUP[8*b +: 8]) | (mPg[8*b +: 8] & ~SUP[8*b +: 8]);
  endtask

  task automatic doWrite(input int off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgDwAddr = 10'(int'(BASE) + off);
    cfgByteEn = be;
    cfgWrData = d;
    cfgWrEn = 1;
    @(negedge clk);
    cfgWrEn = 0;
    modelWrite(off, be, d);
  endtask

  task automatic checkOutputs(input string req);
    check(req, {24'h0, vfEnable}, {24'h0, expVec(mCount)});
    check(req, {16'h0, enabledVfCount}, {16'h0, mCount});
  endtask

  task automatic checkAll();
    for (int off = -2; off < 18; off++) begin
      @(negedge clk);
      cfgDwAddr = 10'(int'(BASE) + off);
      #1;
      check(reqOf(off), cfgRdData, expRead(off));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] r;
    seed = $urandom(32'h5eed_0101);
    mCtrl = 0; mNum = 0; mCount = 0; mPg = 32'h1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    checkOutputs("R9");
    checkAll();
    // R6 enable with a valid count
    doWrite(4, 4'b0011, 32'h0000_0005);
    doWrite(2, 4'b0001, 32'hffff_ffff);
    checkOutputs("R6"); checkAll();
    // R7 count above the total: enable refused
    doWrite(4, 4'b0011, 32'h0000_0009);
    doWrite(2, 4'b0001, 32'h0000_0019);
    checkOutputs("R7"); checkAll();
    // R6 boundary count equal to the total
    doWrite(4, 4'b0001, 32'h0000_0008);
    doWrite(2, 4'b0001, 32'h0000_0001);
    checkOutputs("R6");
    // R10 control dword without byte 0 does nothing
    doWrite(2, 4'b1110, 32'h0);
    checkOutputs("R10");
    // R1 writes just outside the window
    doWrite(-1, 4'hf, 32'h0);
    doWrite(16, 4'hf, 32'h0);
    doWrite(18, 4'hf, 32'h0);
    checkOutputs("R1"); checkAll();
    // R8 disable
    doWrite(2, 4'b0001, 32'h0000_0018);
    checkOutputs("R8");
    // R3 upper byte only, R5 full page mask
    doWrite(4, 4'b0010, 32'h0000_ab00);
    doWrite(8, 4'hf, 32'hffff_ffff);
    checkAll();
    // R4 read-only dwords ignore writes
    doWrite(0, 4'hf, 32'hffff_ffff);
    doWrite(3, 4'hf, 32'hffff_ffff);
    doWrite(7, 4'hf, 32'h0);
    checkAll();
    for (int n = 0; n < 300; n++) begin
      int off;
      r = $urandom;
      off = int'($urandom_range(0, 23)) - 4;
      if (r[3:0] < 4) off = 4;
      else if (r[3:0] < 8) off = 2;
      if (off == 4 && r[4]) r = {16'h0, 16'($urandom_range(0, NVF + 3))};
      else r = $urandom;
      doWrite(off, 4'($urandom), r);
      checkOutputs((off == 2) ? "R6" : "R1");
      if (n % 25 == 0) checkAll();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule